// File: doc/BRIEF.md
# Section Power and PLL Retune Sequencer

This block decides which of three analog sections of a dual-loop frequency synthesizer are powered: the reference amplifier, the IF section and the RF section. A hardware power pin takes priority over the software control bits. When the pin allows power, the software bits choose the sections. When the pin removes power, everything is off. The one exception is a crystal keep-alive mode, which holds the reference amplifier on.

The block also runs a sequence for each of the IF and RF loops. A sequence starts when the loop's section powers up, or when a new divide value is written while the section is already on. It first runs a self-tune phase and then a settle phase. Both phases are counted in phase-detector update periods, which arrive on a one-cycle `tick` input. The block reports each loop's phase and an active-low lock indicator. Control logic elsewhere uses these outputs to gate the analog tuning and to know when a channel is usable.

Top module: `pwr_retune_seq`

## Requirements
- R1: While `pwr_pin` is 0, `if_on` and `rf_on` are 0. `ref_on` is 1 only if `xtal_keep` is 1 and at least one of `if_req`, `rf_req` is 1.
- R2: While `pwr_pin` is 1, `xtal_keep` has no effect on any output.
- R3: While `pwr_pin` is 1 and `auto_on` is 1, all three enables are 1, whatever `if_req` and `rf_req` are.
- R4: While `pwr_pin` is 1 and `auto_on` is 0:
  - `if_on` equals `if_req`.
  - `rf_on` equals `rf_req`.
  - `ref_on` is 1 when either request is 1.
  - When both requests are 0, all three enables are 0.
- R5: The three enables are registered. They reflect the control inputs one clock after those inputs change.
- R6: In the cycle after a section's enable rises, its loop enters the tune phase (`*_tuning` = 1). It stays there for `TUNE_TICKS` (default 7) cycles with `tick` = 1.
- R7: After tuning, the loop is in the settle phase (`*_settling` = 1) for `SETTLE_TICKS` (default 21) ticks. It then reaches ready (`*_ready` = 1) and holds ready until the next trigger or loss of power.
- R8: A one-cycle divide-write pulse while the section is on puts the loop back in the tune phase on the next cycle. This applies from any phase. The pulse has no effect while the section is off.
- R9: `lock_n` is 1 exactly while either loop is in the tune phase, and 0 otherwise.
- R10: If a section's enable is 0, its loop returns to idle on the next clock. All its phase flags are then 0, and the tune and settle counts are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_pin | input | 1 | Hardware power permit; 0 forces power-down |
| xtal_keep | input | 1 | Crystal keep-alive mode for the reference amplifier |
| auto_on | input | 1 | Software: power every section |
| if_req | input | 1 | Software: IF section on |
| rf_req | input | 1 | Software: RF section on |
| tick | input | 1 | One-cycle pulse per phase-detector update period |
| if_div_wr | input | 1 | Pulse: new IF divide value written |
| rf_div_wr | input | 1 | Pulse: new RF divide value written |
| ref_on | output | 1 | Reference amplifier enable |
| if_on | output | 1 | IF section enable |
| rf_on | output | 1 | RF section enable |
| if_tuning | output | 1 | IF loop in tune phase |
| if_settling | output | 1 | IF loop in settle phase |
| if_ready | output | 1 | IF loop settled |
| rf_tuning | output | 1 | RF loop in tune phase |
| rf_settling | output | 1 | RF loop in settle phase |
| rf_ready | output | 1 | RF loop settled |
| lock_n | output | 1 | Active-low lock: 1 while any loop is tuning |

## Verification
The assertions check the following on every cycle:
- The pin override keeps both sections off.
- The reference amplifier is on whenever a section is on.
- A loop enters tuning one cycle after its enable rises, and after a divide write while on.
- Tuning can only hand over to settling while power holds.
- Ready only follows settling.
- A loop goes idle one cycle after its section loses power.
- `lock_n` follows the tune phase.

Only the bench's scenarios show the following:
- The exact tick counts of each phase, including restarts in the middle of settling.
- The full truth table of the power decode with the crystal mode in both pin states.
- That divide writes are ignored while a section is off.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_TUNE   = 2'd1,
    PH_SETTLE = 2'd2,
    PH_READY  = 2'd3
  } phase_t;

  typedef struct packed {
    logic ref_en;
    logic if_en;
    logic rf_en;
  } pwr_vec_t;

  // Power decision: the pin overrides software, except the crystal keep-alive.
  function automatic pwr_vec_t decode_power(
    input logic pin,
    input logic keep,
    input logic all_on,
    input logic if_bit,
    input logic rf_bit
  );
    pwr_vec_t v;
    if (pin) begin
      if (all_on) begin
        v = '{ref_en: 1'b1, if_en: 1'b1, rf_en: 1'b1};
      end else begin
        v = '{ref_en: if_bit | rf_bit, if_en: if_bit, rf_en: rf_bit};
      end
    end else begin
      v = '{ref_en: keep & (if_bit | rf_bit), if_en: 1'b0, rf_en: 1'b0};
    end
    return v;
  endfunction

  // True when a phase counter sits on its final tick.
  function automatic logic is_last(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

endpackage

// File: rtl/pwr_decode.sv
module pwr_decode
  import pwr_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin,
  input  logic     keep,
  input  logic     all_on,
  input  logic     if_bit,
  input  logic     rf_bit,
  output pwr_vec_t en_q
);

  pwr_vec_t en_d;

  always_comb begin
    en_d = decode_power(pin, keep, all_on, if_bit, rf_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/pll_seq.sv
module pll_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned TUNE_TICKS   = 7,
  parameter int unsigned SETTLE_TICKS = 21
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sec_on,
  input  logic   div_wr,
  input  logic   tick,
  output phase_t phase
);

  localparam int unsigned MAX_TICKS = (TUNE_TICKS > SETTLE_TICKS) ? TUNE_TICKS : SETTLE_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             sec_on_d;
  logic [CNT_W-1:0] cnt;

  // Named internal events
  logic power_rise;
  logic retune_req;
  logic trig;
  logic abort_seq;
  logic tune_done;
  logic settle_done;

  always_comb begin
    power_rise  = sec_on & ~sec_on_d;
    retune_req  = sec_on & div_wr;
    trig        = power_rise | retune_req;
    abort_seq   = ~sec_on;
    tune_done   = (phase == PH_TUNE) & tick & is_last(int'(cnt), TUNE_TICKS);
    settle_done = (phase == PH_SETTLE) & tick & is_last(int'(cnt), SETTLE_TICKS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_on_d <= 1'b0;
      phase    <= PH_IDLE;
      cnt      <= '0;
    end else begin
      sec_on_d <= sec_on;
      if (abort_seq) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (trig) begin
        phase <= PH_TUNE;
        cnt   <= '0;
      end else if (tune_done) begin
        phase <= PH_SETTLE;
        cnt   <= '0;
      end else if (settle_done) begin
        phase <= PH_READY;
        cnt   <= '0;
      end else if (tick && (phase == PH_TUNE || phase == PH_SETTLE)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwr_retune_seq.sv
module pwr_retune_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned TUNE_TICKS   = 7,
  parameter int unsigned SETTLE_TICKS = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_pin,
  input  logic xtal_keep,
  input  logic auto_on,
  input  logic if_req,
  input  logic rf_req,
  input  logic tick,
  input  logic if_div_wr,
  input  logic rf_div_wr,
  output logic ref_on,
  output logic if_on,
  output logic rf_on,
  output logic if_tuning,
  output logic if_settling,
  output logic if_ready,
  output logic rf_tuning,
  output logic rf_settling,
  output logic rf_ready,
  output logic lock_n
);

  localparam int unsigned N_LOOPS = 2;  // index 0: IF, index 1: RF

  pwr_vec_t           en_q;
  logic [N_LOOPS-1:0] sec_on_v;
  logic [N_LOOPS-1:0] div_wr_v;
  phase_t             ph   [N_LOOPS];
  logic [N_LOOPS-1:0] tuning_v;

  pwr_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (pwr_pin),
    .keep   (xtal_keep),
    .all_on (auto_on),
    .if_bit (if_req),
    .rf_bit (rf_req),
    .en_q   (en_q)
  );

  assign sec_on_v = {en_q.rf_en, en_q.if_en};
  assign div_wr_v = {rf_div_wr, if_div_wr};

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
    pll_seq #(
      .TUNE_TICKS   (TUNE_TICKS),
      .SETTLE_TICKS (SETTLE_TICKS)
    ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .sec_on (sec_on_v[g]),
      .div_wr (div_wr_v[g]),
      .tick   (tick),
      .phase  (ph[g])
    );
    assign tuning_v[g] = (ph[g] == PH_TUNE);
  end

  assign ref_on      = en_q.ref_en;
  assign if_on       = en_q.if_en;
  assign rf_on       = en_q.rf_en;
  assign if_tuning   = tuning_v[0];
  assign if_settling = (ph[0] == PH_SETTLE);
  assign if_ready    = (ph[0] == PH_READY);
  assign rf_tuning   = tuning_v[1];
  assign rf_settling = (ph[1] == PH_SETTLE);
  assign rf_ready    = (ph[1] == PH_READY);
  assign lock_n      = |tuning_v;

endmodule

// File: rtl/pwr_retune_seq_chk.sv
module pwr_retune_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_pin,
  input logic if_div_wr,
  input logic rf_div_wr,
  input logic ref_on,
  input logic if_on,
  input logic rf_on,
  input logic if_tuning,
  input logic if_settling,
  input logic if_ready,
  input logic rf_tuning,
  input logic rf_settling,
  input logic rf_ready,
  input logic lock_n
);

  AST_PIN_LOW_SECTIONS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_pin) |-> (!if_on && !rf_on)); // R1

  AST_REF_WITH_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (if_on || rf_on) |-> ref_on); // R4

  AST_IF_PWRUP_TUNES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_on) |=> if_tuning); // R6

  AST_RF_PWRUP_TUNES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_on) |=> rf_tuning); // R6

  AST_IF_TUNE_TO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(if_tuning) && $past(if_on)) |-> if_settling); // R7

  AST_RF_TUNE_TO_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rf_tuning) && $past(rf_on)) |-> rf_settling); // R7

  AST_IF_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_ready) |-> $past(if_settling)); // R7

  AST_RF_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_ready) |-> $past(rf_settling)); // R7

  AST_IF_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (if_on && if_div_wr) |=> if_tuning); // R8

  AST_RF_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_on && rf_div_wr) |=> rf_tuning); // R8

  AST_LOCKN_WHILE_TUNING: assert property (@(posedge clk) disable iff (!rst_n)
    (if_tuning || rf_tuning) |-> lock_n); // R9

  AST_IF_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !if_on |=> (!if_tuning && !if_settling && !if_ready)); // R10

  AST_RF_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_on |=> (!rf_tuning && !rf_settling && !rf_ready)); // R10

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({if_tuning, if_settling, if_ready}) && $onehot0({rf_tuning, rf_settling, rf_ready})); // R7

endmodule

bind pwr_retune_seq pwr_retune_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_pin     (pwr_pin),
  .if_div_wr   (if_div_wr),
  .rf_div_wr   (rf_div_wr),
  .ref_on      (ref_on),
  .if_on       (if_on),
  .rf_on       (rf_on),
  .if_tuning   (if_tuning),
  .if_settling (if_settling),
  .if_ready    (if_ready),
  .rf_tuning   (rf_tuning),
  .rf_settling (rf_settling),
  .rf_ready    (rf_ready),
  .lock_n      (lock_n)
);

// File: tb/pwr_retune_seq_tb.sv
module pwr_retune_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_pin = 1'b0, xtal_keep = 1'b0, auto_on = 1'b0;
  logic if_req = 1'b0, rf_req = 1'b0, tick = 1'b0;
  logic if_div_wr = 1'b0, rf_div_wr = 1'b0;
  logic ref_on, if_on, rf_on;
  logic if_tuning, if_settling, if_ready;
  logic rf_tuning, rf_settling, rf_ready, lock_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  string      q_tag[$];
  logic [9:0] q_exp[$];

  always #4 clk = ~clk;  // 125 MHz

  pwr_retune_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .xtal_keep(xtal_keep),
    .auto_on(auto_on), .if_req(if_req), .rf_req(rf_req), .tick(tick),
    .if_div_wr(if_div_wr), .rf_div_wr(rf_div_wr),
    .ref_on(ref_on), .if_on(if_on), .rf_on(rf_on),
    .if_tuning(if_tuning), .if_settling(if_settling), .if_ready(if_ready),
    .rf_tuning(rf_tuning), .rf_settling(rf_settling), .rf_ready(rf_ready),
    .lock_n(lock_n)
  );

  // Expected vector from bench model: phase codes 0 idle,1 tune,2 settle,3 ready
  function automatic logic [9:0] mk(input logic r, input logic i, input logic f,
                                    input int ip, input int rp);
    return {r, i, f, ip == 1, ip == 2, ip == 3, rp == 1, rp == 2, rp == 3,
            (ip == 1) || (rp == 1)};
  endfunction

  task automatic expect_now(input string tag, input logic [9:0] e);
    q_tag.push_back(tag);
    q_exp.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
      step(1);
    end
  endtask

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    logic [9:0] obs;
    obs = {ref_on, if_on, rf_on, if_tuning, if_settling, if_ready,
           rf_tuning, rf_settling, rf_ready, lock_n};
    while (q_exp.size() > 0) begin
      string      t;
      logic [9:0] e;
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      n_tests++;
      if (obs !== e) begin
        n_fail++;
        $display("FAIL %s actual=%b expected=%b", t, obs, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_now("reset", mk(0, 0, 0, 0, 0));
    step(1);

    // R1: pin low, crystal keep with a request keeps only reference on
    xtal_keep = 1'b1; if_req = 1'b1;
    step(1);
    expect_now("R1 keep+req", mk(1, 0, 0, 0, 0));
    if_req = 1'b0;
    step(1);
    expect_now("R1 keep no req", mk(0, 0, 0, 0, 0));
    xtal_keep = 1'b0; rf_req = 1'b1;
    step(1);
    expect_now("R1 no keep", mk(0, 0, 0, 0, 0));
    // R8: divide write while off ignored
    rf_div_wr = 1'b1; step(1); rf_div_wr = 1'b0;
    expect_now("R8 write while off", mk(0, 0, 0, 0, 0));
    rf_req = 1'b0;
    step(1);

    // R4/R5: pin high, IF only
    pwr_pin = 1'b1; if_req = 1'b1;
    step(1);
    expect_now("R5 registered enable", mk(1, 1, 0, 0, 0));
    step(1);
    expect_now("R6 tune after enable", mk(1, 1, 0, 1, 0));
    ticks(6);
    expect_now("R6 still tuning after 6", mk(1, 1, 0, 1, 0));
    ticks(1);
    expect_now("R7 settle after 7", mk(1, 1, 0, 2, 0));
    ticks(20);
    expect_now("R7 settling after 20", mk(1, 1, 0, 2, 0));
    ticks(1);
    expect_now("R7 ready after 21", mk(1, 1, 0, 3, 0));

    // R2: crystal keep has no effect with pin high
    xtal_keep = 1'b1;
    step(1);
    expect_now("R2 keep ignored", mk(1, 1, 0, 3, 0));
    step(1);
    expect_now("R2 keep ignored later", mk(1, 1, 0, 3, 0));

    // R8: divide write while ready restarts, also during settle
    if_div_wr = 1'b1; step(1); if_div_wr = 1'b0;
    expect_now("R8 restart from ready", mk(1, 1, 0, 1, 0));
    ticks(7);
    ticks(3);
    expect_now("R8 settling mid", mk(1, 1, 0, 2, 0));
    if_div_wr = 1'b1; step(1); if_div_wr = 1'b0;
    expect_now("R8 restart from settle", mk(1, 1, 0, 1, 0));
    ticks(7);
    ticks(21);
    expect_now("R7 ready again", mk(1, 1, 0, 3, 0));

    // R3: auto on powers all, RF starts tuning; R9 lock_n from RF
    auto_on = 1'b1; if_req = 1'b0;
    step(1);
    expect_now("R3 all on", mk(1, 1, 1, 3, 0));
    step(1);
    expect_now("R9 lock_n while RF tunes", mk(1, 1, 1, 3, 1));

    // R4: pin high, auto off, RF only -> IF drops
    auto_on = 1'b0; rf_req = 1'b1;
    step(1);
    expect_now("R4 rf only", mk(1, 0, 1, 3, 1));
    step(1);
    expect_now("R10 IF idle after drop", mk(1, 0, 1, 0, 1));

    // R10 + R1: pin low mid-tune with keep and a request
    pwr_pin = 1'b0;
    step(1);
    expect_now("R1 pin low keep ref", mk(1, 0, 0, 0, 1));
    step(1);
    expect_now("R10 abort to idle", mk(1, 0, 0, 0, 0));

    // R4: both requests 0 with pin high -> all off
    pwr_pin = 1'b1; rf_req = 1'b0; xtal_keep = 1'b0;
    step(1);
    expect_now("R4 both off", mk(0, 0, 0, 0, 0));
    step(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule